// File: doc/BRIEF.md
# Page Write Buffer and Commit Controller

This block sits between a serial-bus protocol engine and the nonvolatile array of a small byte-addressed store. For each write transaction the engine hands it a start strobe with a 12-bit byte address, then one strobe per received data byte, then a stop strobe. The block collects the bytes in a 32-byte page buffer, and records each byte's slot in a per-slot valid mask. Nothing reaches the array while bytes are still arriving.

At stop, if at least one byte was taken in and the write-protect level is low, the block raises busy for a fixed number of system clocks. This stands in for the self-timed programming interval. In the last clock of that interval it issues a single wide write: the page number, all 32 buffered bytes and the valid mask. Only the masked bytes are meant to change. Busy then drops and the buffer is emptied. While busy is high the block ignores every request. A write under protection, or a stop with no data (the address-only phase of a random read), finishes without any programming interval.

Top module: `page_write_buffer`

## Requirements
- R1: A start strobe taken while not busy opens a transaction. Bits 11:5 of the address become the page number presented on `arrPage`, and bits 4:0 become the buffer slot for the first byte.
- R2: Each accepted byte is stored at the current slot. The slot then advances by one modulo 32, wrapping from slot 31 to slot 0, and the page number never changes within the transaction.
- R3: When more than 32 bytes arrive, each later byte overwrites the earlier one in the slot it wraps to. Bit i of `arrByteEn` is 1 exactly when slot i was loaded, and byte lane i of `arrData` is bits 8i+7:8i.
- R4: `arrWrEn` is never high outside the programming interval.
- R5: A stop that follows at least one accepted byte, with `wpLevel` low, raises `busy` on the next clock. `busy` then stays high for exactly WRITE_CYCLES clocks.
- R6: Exactly one `arrWrEn` pulse occurs per programming interval, in its last busy clock. During that pulse `arrData` and `arrByteEn` carry the collected page.
- R7: A transaction with exactly one byte commits with exactly one bit set in `arrByteEn`.
- R8: While `busy` is high, start, byte and stop strobes have no effect. The committed page is unchanged, and no new transaction follows the interval.
- R9: A stop with `wpLevel` high raises neither `busy` nor `arrWrEn`, and it discards the buffered bytes (`arrByteEn` returns to 0).
- R10: A stop with no accepted byte since the last start does not start programming. Byte or stop strobes that arrive with no open transaction are also ignored.
- R11: After the programming interval ends, the buffer and mask are empty (`arrByteEn` is 0).
- R12: During and right after reset, `busy` and `arrWrEn` are low and `arrByteEn` is 0.
- R13: A second start strobe inside an open transaction discards the bytes held so far and reloads the address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrStartStb | input | 1 | Opens a write transaction |
| wrAddr | input | 12 | Byte address, sampled with wrStartStb |
| byteValid | input | 1 | One data byte is present |
| byteData | input | 8 | Data byte, sampled with byteValid |
| stopStb | input | 1 | Bus stop seen; ends the transaction |
| wpLevel | input | 1 | High protects the whole array |
| busy | output | 1 | Programming interval in progress |
| arrWrEn | output | 1 | One-clock array write strobe |
| arrPage | output | 7 | Page number of the write |
| arrByteEn | output | 32 | Per-slot write enables (valid mask) |
| arrData | output | 256 | Page buffer contents, lane i = slot i |

## Verification
The assertions assume that the protocol engine raises at most one of the start, byte and stop strobes in any clock, and that every strobe lasts a single clock. The bench drives each strobe for exactly one clock on the falling edge and never overlaps two strobes. The sweep covers every starting slot, with byte counts from 1 up past 32, so the wrap cases and the single-byte case all occur. Strobes sent during busy are kept within the same one-at-a-time discipline, so any change they cause would show up at the ports.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // Strobes from control to datapath; at most one of loadAddr/storeByte per clock.
  typedef struct packed {
    logic loadAddr;
    logic storeByte;
    logic clearAll;
  } pwbStrobes_t;
endpackage

// File: rtl/pwb_ctrl.sv
module pwb_ctrl
  import pwb_pkg::*;
#(
  parameter int WRITE_CYCLES = 1000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startStb,
  input  logic        byteStb,
  input  logic        stopStb,
  input  logic        wpLevel,
  input  logic        anyValid,
  output pwbStrobes_t strobes,
  output logic        busy,
  output logic        commitStb
);
  localparam int CNT_W = (WRITE_CYCLES < 2) ? 1 : $clog2(WRITE_CYCLES);

  typedef enum logic [1:0] {S_IDLE, S_LOAD, S_PROG} pwbState_t;

  pwbState_t        state, stateNext;
  logic [CNT_W-1:0] progCnt, cntNext;
  logic             lastTick;

  assign lastTick  = (state == S_PROG) && (progCnt == CNT_W'(WRITE_CYCLES - 1));
  assign busy      = (state == S_PROG);
  assign commitStb = lastTick;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      progCnt <= '0;
    end else begin
      state   <= stateNext;
      progCnt <= cntNext;
    end
  end

  always_comb begin
    stateNext = state;
    cntNext   = progCnt;
    strobes   = '0;
    unique case (state)
      S_IDLE: begin
        if (startStb) begin
          stateNext         = S_LOAD;
          strobes.loadAddr  = 1'b1;
          strobes.clearAll  = 1'b1;
        end
      end
      S_LOAD: begin
        if (startStb) begin
          strobes.loadAddr = 1'b1;
          strobes.clearAll = 1'b1;
        end else if (stopStb) begin
          if (anyValid && !wpLevel) begin
            stateNext = S_PROG;
            cntNext   = '0;
          end else begin
            stateNext        = S_IDLE;
            strobes.clearAll = 1'b1;
          end
        end else if (byteStb) begin
          strobes.storeByte = 1'b1;
        end
      end
      S_PROG: begin
        if (lastTick) begin
          stateNext        = S_IDLE;
          strobes.clearAll = 1'b1;
          cntNext          = '0;
        end else begin
          cntNext = progCnt + 1'b1;
        end
      end
      default: stateNext = S_IDLE;
    endcase
  end

  // R5: programming only begins from an unprotected stop holding data
  p_busy_from_stop_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> ($past(stopStb) && $past(anyValid) && !$past(wpLevel)));
  // R5: busy holds until the commit clock
  p_busy_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !commitStb) |=> busy);
  // R6: the commit clock is the last busy clock
  p_commit_last_r6: assert property (@(posedge clk) disable iff (!rstN)
    commitStb |=> !busy);
  // R9: protected stop never starts programming
  p_wp_blocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && wpLevel && stopStb) |=> !busy);
  // R10: empty stop never starts programming
  p_empty_stop_r10: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && stopStb && !anyValid) |=> !busy);
endmodule

// File: rtl/pwb_datapath.sv
module pwb_datapath
  import pwb_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int OFFS_W = 5,
  parameter int DATA_W = 8
) (
  input  logic                                clk,
  input  logic                                rstN,
  input  pwbStrobes_t                         strobes,
  input  logic [ADDR_W-1:0]                   addrIn,
  input  logic [DATA_W-1:0]                   byteIn,
  output logic [ADDR_W-OFFS_W-1:0]            pageOut,
  output logic [(2**OFFS_W)*DATA_W-1:0]       dataOut,
  output logic [(2**OFFS_W)-1:0]              maskOut,
  output logic                                anyValid
);
  localparam int PAGE_BYTES = 2 ** OFFS_W;
  localparam int PAGE_W     = ADDR_W - OFFS_W;

  logic [PAGE_W-1:0]     pageReg;
  logic [OFFS_W-1:0]     offsReg;
  logic [PAGE_BYTES-1:0] validMask;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pageReg <= '0;
      offsReg <= '0;
    end else if (strobes.loadAddr) begin
      pageReg <= addrIn[ADDR_W-1:OFFS_W];
      offsReg <= addrIn[OFFS_W-1:0];
    end else if (strobes.storeByte) begin
      offsReg <= offsReg + 1'b1;
    end
  end

  for (genvar i = 0; i < PAGE_BYTES; i++) begin : g_slot
    logic [DATA_W-1:0] slotReg;
    logic              hit;
    assign hit = strobes.storeByte && (offsReg == OFFS_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        slotReg      <= '0;
        validMask[i] <= 1'b0;
      end else if (strobes.clearAll) begin
        slotReg      <= '0;
        validMask[i] <= 1'b0;
      end else if (hit) begin
        slotReg      <= byteIn;
        validMask[i] <= 1'b1;
      end
    end

    assign dataOut[i*DATA_W +: DATA_W] = slotReg;
  end

  assign pageOut  = pageReg;
  assign maskOut  = validMask;
  assign anyValid = |validMask;

  // R2: slot pointer steps by one, modulo page size, page fixed
  p_offs_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.storeByte && !strobes.loadAddr) |=>
      (offsReg == OFFS_W'($past(offsReg) + 1'b1)) && $stable(pageReg));
  // R3: a stored byte marks its slot valid
  p_slot_marked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.storeByte && !strobes.clearAll) |=> validMask[$past(offsReg)]);
  // R11: a clear empties the mask
  p_clear_r11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clearAll |=> (validMask == '0));
endmodule

// File: rtl/page_write_buffer.sv
module page_write_buffer
  import pwb_pkg::*;
#(
  parameter int ADDR_W       = 12,
  parameter int OFFS_W       = 5,
  parameter int DATA_W       = 8,
  parameter int WRITE_CYCLES = 1000
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  wrStartStb,
  input  logic [ADDR_W-1:0]                     wrAddr,
  input  logic                                  byteValid,
  input  logic [DATA_W-1:0]                     byteData,
  input  logic                                  stopStb,
  input  logic                                  wpLevel,
  output logic                                  busy,
  output logic                                  arrWrEn,
  output logic [ADDR_W-OFFS_W-1:0]              arrPage,
  output logic [(2**OFFS_W)-1:0]                arrByteEn,
  output logic [(2**OFFS_W)*DATA_W-1:0]         arrData
);
  pwbStrobes_t strobes;
  logic        anyValid;

  pwb_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .startStb  (wrStartStb),
    .byteStb   (byteValid),
    .stopStb   (stopStb),
    .wpLevel   (wpLevel),
    .anyValid  (anyValid),
    .strobes   (strobes),
    .busy      (busy),
    .commitStb (arrWrEn)
  );

  pwb_datapath #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .addrIn   (wrAddr),
    .byteIn   (byteData),
    .pageOut  (arrPage),
    .dataOut  (arrData),
    .maskOut  (arrByteEn),
    .anyValid (anyValid)
  );

  // R4: array writes happen only inside the programming interval
  p_write_in_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> busy);
  // R6: a commit always carries at least one enabled byte
  p_commit_has_data_r6: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |-> (arrByteEn != '0));
  // R8: the held page is frozen while programming
  p_frozen_busy_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !arrWrEn) |=> ($stable(arrByteEn) && $stable(arrData) && $stable(arrPage)));
  // R11: mask empty after the commit clock
  p_empty_after_r11: assert property (@(posedge clk) disable iff (!rstN)
    arrWrEn |=> (arrByteEn == '0));
endmodule

// File: tb/tb_page_write_buffer.sv
module tb_page_write_buffer;
  localparam int WC = 16;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         wrStartStb = 1'b0;
  logic [11:0]  wrAddr = '0;
  logic         byteValid = 1'b0;
  logic [7:0]   byteData = '0;
  logic         stopStb = 1'b0;
  logic         wpLevel = 1'b0;
  logic         busy, arrWrEn;
  logic [6:0]   arrPage;
  logic [31:0]  arrByteEn;
  logic [255:0] arrData;

  int  nChecks = 0;
  int  nFails  = 0;
  bit  done    = 1'b0;

  page_write_buffer #(.WRITE_CYCLES(WC)) dut (
    .clk(clk), .rstN(rstN), .wrStartStb(wrStartStb), .wrAddr(wrAddr),
    .byteValid(byteValid), .byteData(byteData), .stopStb(stopStb),
    .wpLevel(wpLevel), .busy(busy), .arrWrEn(arrWrEn), .arrPage(arrPage),
    .arrByteEn(arrByteEn), .arrData(arrData)
  );

  always #5 clk = ~clk;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [255:0] act, input logic [255:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic pulseStart(input logic [11:0] a);
    @(negedge clk); wrStartStb = 1'b1; wrAddr = a;
    @(negedge clk); wrStartStb = 1'b0;
  endtask

  task automatic pulseByte(input logic [7:0] d);
    @(negedge clk); byteValid = 1'b1; byteData = d;
    @(negedge clk); byteValid = 1'b0;
  endtask

  task automatic pulseStop();
    @(negedge clk); stopStb = 1'b1;
    @(negedge clk); stopStb = 1'b0;
  endtask

  // Follows a programming interval from the negedge after stop to busy low.
  task automatic runCommit(output int busyLen, output int wrCount, output int wrPos,
                           output logic [6:0] pg, output logic [31:0] m,
                           output logic [255:0] d);
    busyLen = 0; wrCount = 0; wrPos = -1; pg = '0; m = '0; d = '0;
    while (busy && busyLen < 1000) begin
      if (arrWrEn) begin
        wrCount++; wrPos = busyLen; pg = arrPage; m = arrByteEn; d = arrData;
      end
      busyLen++;
      @(negedge clk);
    end
  endtask

  // Counts busy and write strobes over a window of idle clocks.
  task automatic watchIdle(input int cycles, output int busySeen, output int wrSeen);
    busySeen = 0; wrSeen = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      if (busy) busySeen++;
      if (arrWrEn) wrSeen++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      nFails++; nChecks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int busyLen, wrCount, wrPos, bs, ws;
    logic [6:0]   pg;
    logic [31:0]  m, expM;
    logic [255:0] d, expD;

    // R12: reset state
    repeat (3) @(negedge clk);
    check(!busy && !arrWrEn && arrByteEn == '0, "R12", "outputs in reset",
          {arrByteEn, busy, arrWrEn}, '0);
    rstN = 1'b1;
    @(negedge clk);
    check(!busy && !arrWrEn && arrByteEn == '0, "R12", "outputs after reset",
          {arrByteEn, busy, arrWrEn}, '0);

    // Sweep every start slot with byte counts 1..40 (wrap, overwrite, single byte)
    for (int off = 0; off < 32; off++) begin
      int n;
      logic [6:0] page;
      n = (off * 5) % 40 + 1;
      page = 7'((off * 3 + 1) % 128);
      expM = '0; expD = '0;
      pulseStart({page, 5'(off)});
      for (int k = 0; k < n; k++) begin
        int slot;
        logic [7:0] v;
        slot = (off + k) % 32;
        v = 8'((off * 37 + k * 11 + 5) & 255);
        pulseByte(v);
        expD[slot*8 +: 8] = v;
        expM[slot] = 1'b1;
      end
      check(!busy && !arrWrEn, "R4", "no write before stop", {busy, arrWrEn}, '0);
      pulseStop();
      runCommit(busyLen, wrCount, wrPos, pg, m, d);
      check(busyLen == WC, "R5", "busy length", busyLen, WC);
      check(wrCount == 1 && wrPos == WC - 1, "R6", "single commit in last busy clock",
            {wrCount, wrPos}, {32'd1, 32'(WC - 1)});
      check(pg == page, "R1", "committed page", pg, page);
      check(m == expM, "R3", "byte enables", m, expM);
      check(d == expD, "R2", "page data", d, expD);
      if (n == 1) check($countones(m) == 1, "R7", "single byte mask", $countones(m), 1);
      check(arrByteEn == '0 && !busy, "R11", "empty after commit", arrByteEn, '0);
    end

    // R10: stop with no data after the address
    pulseStart(12'h3C4);
    pulseStop();
    watchIdle(WC + 4, bs, ws);
    check(bs == 0 && ws == 0, "R10", "empty stop starts nothing", {bs, ws}, '0);
    // R10: bytes and stop with no open transaction
    pulseByte(8'h5A);
    pulseStop();
    watchIdle(WC + 4, bs, ws);
    check(bs == 0 && ws == 0 && arrByteEn == '0, "R10", "orphan strobes ignored",
          {arrByteEn, bs, ws}, '0);

    // R9: protected write completes but never programs
    pulseStart(12'h7E0);
    for (int k = 0; k < 4; k++) pulseByte(8'(8'h90 + k));
    check(arrByteEn == 32'h0000_000F, "R9", "bytes accepted under protect", arrByteEn,
          32'h0000_000F);
    wpLevel = 1'b1;
    pulseStop();
    watchIdle(WC + 4, bs, ws);
    wpLevel = 1'b0;
    check(bs == 0 && ws == 0, "R9", "no busy under protect", {bs, ws}, '0);
    check(arrByteEn == '0, "R9", "buffer discarded", arrByteEn, '0);

    // R8: strobes during busy are ignored
    pulseStart(12'h0A0);
    pulseByte(8'h11); pulseByte(8'h22); pulseByte(8'h33);
    pulseStop();
    pulseStart(12'h0FF);
    pulseByte(8'hEE);
    pulseStop();
    runCommit(busyLen, wrCount, wrPos, pg, m, d);
    check(wrCount == 1 && pg == 7'd5 && m == 32'h7 && d[23:0] == 24'h332211,
          "R8", "commit unchanged by busy strobes", {pg, m, d[23:0]},
          {7'd5, 32'h7, 24'h332211});
    watchIdle(WC + 4, bs, ws);
    check(bs == 0 && ws == 0 && arrByteEn == '0, "R8", "no transaction after busy",
          {arrByteEn, bs, ws}, '0);

    // R13: second start discards held bytes
    pulseStart(12'h040);
    pulseByte(8'hA1); pulseByte(8'hA2); pulseByte(8'hA3);
    pulseStart(12'h09E);
    pulseByte(8'hB1); pulseByte(8'hB2);
    pulseStop();
    runCommit(busyLen, wrCount, wrPos, pg, m, d);
    expD = '0; expD[30*8 +: 8] = 8'hB1; expD[31*8 +: 8] = 8'hB2;
    check(m == 32'hC000_0000 && pg == 7'd4, "R13", "only restarted bytes enabled",
          {pg, m}, {7'd4, 32'hC000_0000});
    check(d == expD, "R13", "restarted data", d, expD);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule